// File: doc/BRIEF.md
# S/PDIF Pin-Sharing Output Router

This block drives one digital audio output pin from one of two sources. The first source is the stream from an on-chip S/PDIF encoder. The second is a raw copy of one of seven external S/PDIF inputs. Those external inputs do not have pins of their own. They borrow the data pin of serial input 3 and the bit-clock and frame-clock pins of the three serial ports.

A configuration word sets up the routing. It holds a seven-bit mask that claims pins for S/PDIF use, a three-bit index that picks the pass-through input, and a source-select bit. From the mask the block decodes what each shared pin is now doing. It tells the serial-port logic which bit clocks and frame clocks can no longer time serial data inputs 0 to 3. It also tells the processor feed that serial data input 3 carries no valid audio.

Every input pin passes through a two-flop synchronizer. The output is registered, so a change of source takes effect at a clock edge and never passes through an intermediate source. If the configuration asks for a pass-through input that is not claimed, the output is held low and a sticky error flag is set.

Top module: `spdif_pin_router`

## Requirements
- R1: While reset is asserted and at the first sample after it, `tx_out`, `bclk_lost`, `fclk_lost`, `sd3_invalid` and `cfg_err` are all 0.
- R2: With `cfg_src_pass` = 0, `tx_out` equals the value of `enc_stream` sampled at the previous rising edge.
- R3: With `cfg_src_pass` = 1 and the selected input claimed, `tx_out` equals the selected pin's level as sampled three rising edges earlier. That is two synchronizer flops plus the output register, with no other processing.
- R4: Pass-through index k selects pins in this fixed order: 0 = `sd_in3_pin`, 1 = `frm_clk_pin[0]`, 2 = `bit_clk_pin[0]`, 3 = `frm_clk_pin[1]`, 4 = `bit_clk_pin[1]`, 5 = `frm_clk_pin[2]`, 6 = `bit_clk_pin[2]`. Mask bit k claims that same pin.
- R5: All seven mask bits may be set at once. Any of the seven indices then passes through without raising `cfg_err`.
- R6: One edge after the configuration is sampled, `fclk_lost[j]` equals mask bit 1+2j and `bclk_lost[j]` equals mask bit 2+2j, for each port j of 0..2.
- R7: One edge after the configuration is sampled, `sd3_invalid` equals mask bit 0.
- R8: If `cfg_src_pass` = 1 and the index is unclaimed (its mask bit is clear, or the index is 7), then `tx_out` is 0 after the next edge and `cfg_err` is 1.
- R9: Once set, `cfg_err` stays at 1 until reset, whatever the configuration does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_spdif_mask | input | 7 | Claims shared pins for S/PDIF, bit order as in R4 |
| cfg_pass_idx | input | 3 | Pass-through input index |
| cfg_src_pass | input | 1 | 0 = encoder stream, 1 = pass-through |
| enc_stream | input | 1 | Internal encoder output |
| sd_in3_pin | input | 1 | Serial data input 3 pin |
| frm_clk_pin | input | 3 | Frame-clock pins of the three ports |
| bit_clk_pin | input | 3 | Bit-clock pins of the three ports |
| tx_out | output | 1 | Routed output pin |
| bclk_lost | output | 3 | Bit clock j is claimed and unusable |
| fclk_lost | output | 3 | Frame clock j is claimed and unusable |
| sd3_invalid | output | 1 | Serial data input 3 carries no valid audio |
| cfg_err | output | 1 | Sticky: an unclaimed pass-through was requested |

## Verification
Suppose a synchronizer stage is lost or added, or the pin order is scrambled. In pass-through mode `tx_out` then shows the wrong pin, or the right pin one cycle early or late, as soon as that pin toggles. A mask decode that is off by one bit shows on `bclk_lost`, `fclk_lost` or `sd3_invalid` one edge after the mask is applied. A sticky flag that is not sticky shows on `cfg_err` on the first edge after the bad request is withdrawn. The bench compares every port against a cycle model on every cycle, so each of these faults is caught within a few cycles of the stimulus that exposes it.

// File: rtl/spdif_route_pkg.sv
package spdif_route_pkg;

   typedef enum logic {
      SRC_ENCODER = 1'b0,
      SRC_PASSTHRU = 1'b1
   } route_src_e;

   // Shared-pin vector slot of the data pin; port j clocks follow at 1+2j / 2+2j
   localparam int unsigned SLOT_SD3 = 0;

   function automatic int unsigned frm_slot(input int unsigned port);
      return 1 + 2 * port;
   endfunction

   function automatic int unsigned bit_slot(input int unsigned port);
      return 2 + 2 * port;
   endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pin_func_decode.sv
module pin_func_decode
   import spdif_route_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 3,
   localparam int unsigned NUM_IN = 1 + 2 * NUM_PORTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_IN-1:0]    mask,
   output logic [NUM_PORTS-1:0] bclk_lost,
   output logic [NUM_PORTS-1:0] fclk_lost,
   output logic                 sd3_invalid
);

   logic [NUM_PORTS-1:0] bclk_d;
   logic [NUM_PORTS-1:0] fclk_d;

   for (genvar j = 0; j < NUM_PORTS; j++) begin : g_port
      assign fclk_d[j] = mask[frm_slot(j)];
      assign bclk_d[j] = mask[bit_slot(j)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_lost   <= '0;
         fclk_lost   <= '0;
         sd3_invalid <= 1'b0;
      end else begin
         bclk_lost   <= bclk_d;
         fclk_lost   <= fclk_d;
         sd3_invalid <= mask[SLOT_SD3];
      end
   end

endmodule

// File: rtl/route_out_sel.sv
module route_out_sel
   import spdif_route_pkg::*;
#(
   parameter int unsigned NUM_IN = 7,
   localparam int unsigned IDX_W = $clog2(NUM_IN),
   localparam int unsigned EXT_W = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] mask,
   input  logic [IDX_W-1:0]  idx,
   input  route_src_e        src,
   input  logic              enc_bit,
   input  logic [NUM_IN-1:0] pins_sync,
   output logic              tx_q,
   output logic              err_q
);

   logic [EXT_W-1:0] mask_ext;
   logic [EXT_W-1:0] pins_ext;
   logic             sel_live;
   logic             tx_d;

   assign mask_ext = EXT_W'(mask);
   assign pins_ext = EXT_W'(pins_sync);
   assign sel_live = mask_ext[idx];

   always_comb begin
      unique case (src)
         SRC_ENCODER:  tx_d = enc_bit;
         SRC_PASSTHRU: tx_d = sel_live & pins_ext[idx];
         default:      tx_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         tx_q  <= tx_d;
         err_q <= err_q | ((src == SRC_PASSTHRU) & ~sel_live);
      end
   end

endmodule

// File: rtl/spdif_pin_router.sv
module spdif_pin_router
   import spdif_route_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_IN = 1 + 2 * NUM_PORTS,
   localparam int unsigned IDX_W  = $clog2(NUM_IN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_IN-1:0]    cfg_spdif_mask,
   input  logic [IDX_W-1:0]     cfg_pass_idx,
   input  logic                 cfg_src_pass,
   input  logic                 enc_stream,
   input  logic                 sd_in3_pin,
   input  logic [NUM_PORTS-1:0] frm_clk_pin,
   input  logic [NUM_PORTS-1:0] bit_clk_pin,
   output logic                 tx_out,
   output logic [NUM_PORTS-1:0] bclk_lost,
   output logic [NUM_PORTS-1:0] fclk_lost,
   output logic                 sd3_invalid,
   output logic                 cfg_err
);

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("spdif_pin_router: NUM_PORTS must be at least 1");
   end

   logic [NUM_IN-1:0] pins_raw;
   logic [NUM_IN-1:0] pins_sync;
   route_src_e        src_sel;

   assign pins_raw[SLOT_SD3] = sd_in3_pin;
   for (genvar j = 0; j < NUM_PORTS; j++) begin : g_pins
      assign pins_raw[frm_slot(j)] = frm_clk_pin[j];
      assign pins_raw[bit_slot(j)] = bit_clk_pin[j];
   end

   assign src_sel = cfg_src_pass ? SRC_PASSTHRU : SRC_ENCODER;

   pin_sync #(
      .WIDTH (NUM_IN),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_sync)
   );

   pin_func_decode #(
      .NUM_PORTS(NUM_PORTS)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask       (cfg_spdif_mask),
      .bclk_lost  (bclk_lost),
      .fclk_lost  (fclk_lost),
      .sd3_invalid(sd3_invalid)
   );

   route_out_sel #(
      .NUM_IN(NUM_IN)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask     (cfg_spdif_mask),
      .idx      (cfg_pass_idx),
      .src      (src_sel),
      .enc_bit  (enc_stream),
      .pins_sync(pins_sync),
      .tx_q     (tx_out),
      .err_q    (cfg_err)
   );

endmodule

// File: rtl/spdif_pin_router_chk.sv
module spdif_pin_router_chk #(
   parameter int unsigned NUM_PORTS = 3,
   localparam int unsigned NUM_IN = 1 + 2 * NUM_PORTS,
   localparam int unsigned IDX_W  = $clog2(NUM_IN)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_IN-1:0]    cfg_spdif_mask,
   input logic [IDX_W-1:0]     cfg_pass_idx,
   input logic                 cfg_src_pass,
   input logic                 enc_stream,
   input logic                 tx_out,
   input logic [NUM_PORTS-1:0] bclk_lost,
   input logic [NUM_PORTS-1:0] fclk_lost,
   input logic                 sd3_invalid,
   input logic                 cfg_err
);

   logic live_sel;
   assign live_sel = (32'(cfg_pass_idx) < NUM_IN) && cfg_spdif_mask[cfg_pass_idx];

   // R2
   enc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_src_pass |=> tx_out == $past(enc_stream));

   // R6
   clk_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (bclk_lost == {$past(cfg_spdif_mask[6]), $past(cfg_spdif_mask[4]), $past(cfg_spdif_mask[2])})
            && (fclk_lost == {$past(cfg_spdif_mask[5]), $past(cfg_spdif_mask[3]), $past(cfg_spdif_mask[1])}));

   // R7
   sd3_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> sd3_invalid == $past(cfg_spdif_mask[0]));

   // R8
   dead_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src_pass && !live_sel) |=> (!tx_out && cfg_err));

   // R9
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

endmodule

bind spdif_pin_router spdif_pin_router_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_spdif_mask(cfg_spdif_mask),
   .cfg_pass_idx  (cfg_pass_idx),
   .cfg_src_pass  (cfg_src_pass),
   .enc_stream    (enc_stream),
   .tx_out        (tx_out),
   .bclk_lost     (bclk_lost),
   .fclk_lost     (fclk_lost),
   .sd3_invalid   (sd3_invalid),
   .cfg_err       (cfg_err)
);

// File: tb/spdif_pin_router_tb.sv
module spdif_pin_router_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] mask = '0;
   logic [2:0] idx = '0;
   logic       src_pass = 1'b0;
   logic       enc = 1'b0;
   logic       sd3 = 1'b0;
   logic [2:0] frm = '0;
   logic [2:0] bck = '0;
   logic       tx;
   logic [2:0] bl, fl;
   logic       sdinv, err;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   spdif_pin_router u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_spdif_mask(mask), .cfg_pass_idx(idx),
      .cfg_src_pass(src_pass), .enc_stream(enc), .sd_in3_pin(sd3),
      .frm_clk_pin(frm), .bit_clk_pin(bck), .tx_out(tx), .bclk_lost(bl),
      .fclk_lost(fl), .sd3_invalid(sdinv), .cfg_err(err)
   );

   // Pin vector in R4 order: sd3, frm0, bck0, frm1, bck1, frm2, bck2
   function automatic logic [6:0] pin_vec(input logic s, input logic [2:0] f, input logic [2:0] b);
      return {b[2], f[2], b[1], f[1], b[0], f[0], s};
   endfunction

   function automatic logic live(input logic [6:0] m, input logic [2:0] k);
      return (k < 3'd7) && m[k];
   endfunction

   function automatic logic exp_tx(input logic sp, input logic [6:0] m, input logic [2:0] k,
                                   input logic e, input logic [6:0] p);
      if (!sp) return e;
      if (!live(m, k)) return 1'b0;
      return p[k];
   endfunction

   // Reference cycle model
   logic [6:0] m_p1, m_p2;
   logic       m_tx, m_err, m_sd;
   logic [2:0] m_bl, m_fl;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_p1 <= '0; m_p2 <= '0; m_tx <= 1'b0; m_err <= 1'b0;
         m_sd <= 1'b0; m_bl <= '0; m_fl <= '0;
      end else begin
         m_p1  <= pin_vec(sd3, frm, bck);
         m_p2  <= m_p1;
         m_tx  <= exp_tx(src_pass, mask, idx, enc, m_p2);
         m_err <= m_err | (src_pass & ~live(mask, idx));
         m_sd  <= mask[0];
         m_bl  <= {mask[6], mask[4], mask[2]};
         m_fl  <= {mask[5], mask[3], mask[1]};
      end
   end

   task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tx == m_tx, {tag, " R2/R3/R4 tx_out"}, 8'(tx), 8'(m_tx));
      chk(bl == m_bl, {tag, " R6 bclk_lost"}, 8'(bl), 8'(m_bl));
      chk(fl == m_fl, {tag, " R6 fclk_lost"}, 8'(fl), 8'(m_fl));
      chk(sdinv == m_sd, {tag, " R7 sd3_invalid"}, 8'(sdinv), 8'(m_sd));
      chk(err == m_err, {tag, " R8/R9 cfg_err"}, 8'(err), 8'(m_err));
   endtask

   task automatic step(input string tag);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      // R1: reset state
      repeat (3) @(negedge clk);
      chk({tx, bl, fl, sdinv, err} == '0, "R1 reset outputs", 8'({tx, bl, fl, sdinv, err}), 8'h00);
      rst_n = 1'b1;
      step("R1 first");
      chk({tx, bl, fl, sdinv, err} == '0, "R1 after release", 8'({tx, bl, fl, sdinv, err}), 8'h00);

      // R2: encoder stream, one-edge latency
      for (int i = 0; i < 20; i++) begin
         enc = 1'($urandom);
         step("R2 enc");
      end

      // R5 + R4 + R3: all pins claimed, walk each index with a single high pin
      mask = 7'h7f; src_pass = 1'b1;
      for (int k = 0; k < 7; k++) begin
         idx = 3'(k);
         {bck[2], frm[2], bck[1], frm[1], bck[0], frm[0], sd3} = 7'(1 << k);
         for (int c = 0; c < 4; c++) step("R5 walk");
         chk(tx == 1'b1, "R4 selected pin high", 8'(tx), 8'h01);
         {bck[2], frm[2], bck[1], frm[1], bck[0], frm[0], sd3} = ~7'(1 << k);
         for (int c = 0; c < 4; c++) step("R5 walk");
         chk(tx == 1'b0, "R3 selected pin low", 8'(tx), 8'h00);
         chk(err == 1'b0, "R5 no error", 8'(err), 8'h00);
      end

      // R3: exact three-edge latency on a single toggle
      idx = 3'd2; bck[0] = 1'b0;
      repeat (4) step("R3 pre");
      bck[0] = 1'b1;
      step("R3 lat1"); step("R3 lat2");
      chk(tx == 1'b0, "R3 not before third edge", 8'(tx), 8'h00);
      step("R3 lat3");
      chk(tx == 1'b1, "R3 at third edge", 8'(tx), 8'h01);

      // R8 + R9: index 7, then unclaimed index, then back to valid
      idx = 3'd7; step("R8 idx7");
      chk(err == 1'b1, "R8 idx7 sets error", 8'(err), 8'h01);
      chk(tx == 1'b0, "R8 idx7 output low", 8'(tx), 8'h00);
      idx = 3'd0; src_pass = 1'b0;
      repeat (3) step("R9 hold");
      chk(err == 1'b1, "R9 sticky", 8'(err), 8'h01);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      mask = 7'h7e; idx = 3'd0; src_pass = 1'b1; sd3 = 1'b1;
      repeat (4) step("R8 unclaimed");
      chk(tx == 1'b0 && err == 1'b1, "R8 unclaimed low+err", 8'({tx, err}), 8'h01);

      // Random mix
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      for (int n = 0; n < 4000; n++) begin
         if ((n % 25) == 0) begin
            mask = 7'($urandom);
            idx = 3'($urandom);
            src_pass = 1'($urandom);
            if (($urandom % 4) != 0 && src_pass) mask[idx == 3'd7 ? 0 : idx] = 1'b1;
         end
         if ((n % 600) == 599) begin
            rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
         end
         enc = 1'($urandom);
         {bck, frm, sd3} = 7'($urandom);
         step("rand");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule